// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Receiver

This block receives words over a two-wire clocked serial link on which it is the clock master. It generates the shift clock from a programmable divisor and captures the data line on each falling edge of that clock. Words are 8 bits long, or 9 bits when the extended mode is on. The first bit captured is bit 0. Each finished word goes into a single holding register and raises a completion flag. That flag can drive an interrupt.

Software controls the block through a small strobe bus. It can start a reception in two ways. A one-shot enable takes exactly one word and then clears itself. A repeating enable keeps the clock running word after word until software clears it. If both enables are set, the repeating enable decides. If a word finishes while the previous one is still unread, an overrun flag is set and the new words are discarded. Clearing the repeating enable is the only way to clear that flag.

The sequencer has four states. `ST_IDLE` holds the clock at its idle level. `ST_HIGH` is the first half of a bit period, with the internal clock high. `ST_LOW` is the second half, with the internal clock low. `ST_WRAP` lasts one cycle and hands the finished word over. The transitions are as follows:
- IDLE→HIGH when the port is on and either enable is set.
- HIGH→LOW on a divisor tick; this is the falling edge, and the data line is sampled here.
- LOW→HIGH on a tick when more bits are due, and LOW→WRAP on a tick after the last bit.
- WRAP→HIGH when the repeating enable is still set, and WRAP→IDLE otherwise.
- HIGH or LOW→IDLE at once if the port is switched off or both enables drop.

Top module: `sync_rx_master`

Register map (address on `bus_addr`):
- 0 control: b0 port on, b1 one-shot enable, b2 repeating enable, b3 nine-bit mode, b4 clock invert, b5 wide divisor, b6 interrupt enable.
- 1 divisor low byte.
- 2 divisor high byte.
- 3 received data; reading it clears the done flag.
- 4 status: b0 done, b1 overrun, b2 ninth received bit.

## Requirements
- R1: After reset, `sclk_o` is 0 and `irq_o` is 0, and both the control and status registers read 0.
- R2: Setting the one-shot enable (control b1) with the port on receives exactly one word. Control b1 then reads 0, the clock returns to its idle level, and no further word arrives.
- R3: With the repeating enable (control b2) set, words are received back to back until b2 is cleared. When b1 and b2 are both set, reception does not stop after the first word.
- R4: The data line is sampled at each falling edge of the internal shift clock. The first sampled bit becomes data bit 0 (least significant bit first).
- R5: Control b4 inverts `sclk_o`, including its idle level. The sampling point relative to the data does not change.
- R6: Each half of a bit period lasts divisor+1 system clocks. With control b5 = 0 only the low byte is used and the high byte is ignored. With b5 = 1 the divisor is {high, low}.
- R7: With control b3 = 1 a ninth bit is received. That bit reads back in status b2, and the data register holds the low eight bits.
- R8: Status b0 (done) is set when a word completes and is cleared by reading the data register. `irq_o` is high exactly when done and control b6 are both 1.
- R9: A word that completes while done is still set leaves the data unchanged and sets status b1 (overrun). Later words are dropped while b1 is set. Writing the control register with b2 = 0 clears b1.
- R10: While control b0 is 0, `sclk_o` stays at its idle level and no word is received, even if an enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| sclk_o | output | 1 | Generated shift clock |
| sdata_i | input | 1 | Serial data line |
| irq_o | output | 1 | Word-ready interrupt |

## Verification
The assertions assume the following about the inputs:
- The divisor, the nine-bit mode and the clock-invert bit are not rewritten while a word is in flight.
- The data line does not change in the system cycle where the internal clock falls.

The stimulus keeps to these assumptions. It reconfigures only while the sequencer is idle or being stopped. It changes the serial data only just after it sees a rising edge of the shift clock, which leaves at least one full system cycle before the sampling edge, even with the smallest divisor.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2,
        ST_WRAP = 2'd3
    } srx_state_e;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_DIV_LO = 3'd1;
    localparam logic [2:0] A_DIV_HI = 3'd2;
    localparam logic [2:0] A_DATA   = 3'd3;
    localparam logic [2:0] A_STAT   = 3'd4;

    localparam int B_PORT   = 0;
    localparam int B_SINGLE = 1;
    localparam int B_CONT   = 2;
    localparam int B_NINE   = 3;
    localparam int B_INV    = 4;
    localparam int B_WIDE   = 5;
    localparam int B_IRQEN  = 6;

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: every half period starts counting from zero
    p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/srx_fsm.sv
module srx_fsm
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            more,
    input  logic            nine,
    input  logic            tick,
    input  logic            sdata_i,
    output logic            run,
    output logic            sclk_int,
    output logic            word_v,
    output logic [DATA_W:0] word
);

    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W + 1);

    srx_state_e       state, nxt;
    logic [SH_W-1:0]  sh;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             fall;

    assign last_cnt = nine ? CNT_W'(SH_W) : CNT_W'(DATA_W);
    assign fall     = (state == ST_HIGH) && tick && go;

    // next-state decode
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = ST_HIGH;
            ST_HIGH: begin
                if (!go)       nxt = ST_IDLE;
                else if (tick) nxt = ST_LOW;
            end
            ST_LOW: begin
                if (!go)       nxt = ST_IDLE;
                else if (tick) nxt = (bit_cnt == last_cnt) ? ST_WRAP : ST_HIGH;
            end
            ST_WRAP: nxt = more ? ST_HIGH : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath: bit counter and shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh      <= '0;
        end else begin
            if (state == ST_IDLE || state == ST_WRAP) begin
                bit_cnt <= '0;
            end else if (fall) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (fall) begin
                sh <= {sdata_i, sh[SH_W-1:1]};
            end
        end
    end

    // outputs
    always_comb begin
        run      = (state == ST_HIGH) || (state == ST_LOW);
        sclk_int = (state == ST_HIGH);
        word_v   = (state == ST_WRAP);
        word     = nine ? sh : {1'b0, sh[SH_W-1:1]};
    end

    // R4: captured bits only move on a falling edge of the internal clock
    p_shift_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sh) |-> $past(state == ST_HIGH));

    // R7: never more samples than a nine-bit word
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(SH_W));

    // R3: the handover state lasts a single cycle
    p_wrap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRAP) |=> (state != ST_WRAP));

endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
    import srx_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sclk_o,
    input  logic       sdata_i,
    output logic       irq_o
);

    localparam int HI_W = DIV_W - 8;

    logic              c_port, c_single, c_cont, c_nine, c_inv, c_wide, c_irqen;
    logic [7:0]        div_lo;
    logic [HI_W-1:0]   div_hi;
    logic [DIV_W-1:0]  div_eff;
    logic [WORD_W-1:0] data_q;
    logic              ninth_q, done_q, ovr_q;

    logic              wr_ctrl, rd_hit, ovr_clr;
    logic              run, tick, sclk_int, word_v;
    logic [WORD_W:0]   word;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign rd_hit  = bus_rd && (bus_addr == A_DATA);
    assign ovr_clr = wr_ctrl && !bus_wdata[B_CONT];
    assign div_eff = c_wide ? {div_hi, div_lo} : DIV_W'(div_lo);

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (div_eff),
        .tick  (tick)
    );

    srx_fsm #(.DATA_W(WORD_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (c_port && (c_single || c_cont)),
        .more     (c_port && c_cont),
        .nine     (c_nine),
        .tick     (tick),
        .sdata_i  (sdata_i),
        .run      (run),
        .sclk_int (sclk_int),
        .word_v   (word_v),
        .word     (word)
    );

    // control and divisor registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {c_port, c_single, c_cont, c_nine, c_inv, c_wide, c_irqen} <= '0;
            div_lo <= '0;
            div_hi <= '0;
        end else begin
            if (wr_ctrl) begin
                c_port   <= bus_wdata[B_PORT];
                c_single <= bus_wdata[B_SINGLE];
                c_cont   <= bus_wdata[B_CONT];
                c_nine   <= bus_wdata[B_NINE];
                c_inv    <= bus_wdata[B_INV];
                c_wide   <= bus_wdata[B_WIDE];
                c_irqen  <= bus_wdata[B_IRQEN];
            end else if (word_v && !c_cont) begin
                c_single <= 1'b0;
            end
            if (bus_wr && bus_addr == A_DIV_LO) div_lo <= bus_wdata;
            if (bus_wr && bus_addr == A_DIV_HI) div_hi <= bus_wdata[HI_W-1:0];
        end
    end

    // holding register, done and overrun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            ninth_q <= 1'b0;
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            if (word_v && !ovr_q) begin
                if (done_q && !rd_hit) begin
                    ovr_q <= 1'b1;
                end else begin
                    data_q  <= word[WORD_W-1:0];
                    ninth_q <= word[WORD_W];
                    done_q  <= 1'b1;
                end
            end else if (rd_hit) begin
                done_q <= 1'b0;
            end
            if (ovr_clr) ovr_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_CTRL:   bus_rdata = {1'b0, c_irqen, c_wide, c_inv, c_nine, c_cont, c_single, c_port};
            A_DIV_LO: bus_rdata = div_lo;
            A_DIV_HI: bus_rdata = 8'(div_hi);
            A_DATA:   bus_rdata = data_q;
            A_STAT:   bus_rdata = {5'b0, ninth_q, ovr_q, done_q};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assign sclk_o = sclk_int ^ c_inv;
    assign irq_o  = done_q && c_irqen;

    // R2: a one-shot word clears its own enable
    p_single_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (word_v && !c_cont && !wr_ctrl) |=> !c_single);

    // R9: an unread word plus a new one raises overrun
    p_overrun_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_v && done_q && !ovr_q && !rd_hit && !ovr_clr) |=> ovr_q);

    // R8: done only rises after a finished word
    p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(word_v));

    // R10: a switched-off port keeps the clock at its idle level
    p_idle_clock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_port && $past(!c_port)) |-> (sclk_o == c_inv));

endmodule

// File: tb/sim_sync_rx_master.sv
module sim_sync_rx_master;

    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] CTRL = 3'd0, DLO = 3'd1, DHI = 3'd2, DATA = 3'd3, STAT = 3'd4;
    localparam logic [7:0] PORT = 8'h01, ONE = 8'h02, REP = 8'h04, NINE = 8'h08,
                           INV = 8'h10, WIDE = 8'h20, IEN = 8'h40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sclk_o, irq_o;
    logic       sdata_i = 1'b0;

    int   vectors = 0;
    int   miscompares = 0;
    logic inv_tb = 1'b0;
    logic prev_eff = 1'b0;
    logic       bitq[$];
    logic [8:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_rx_master u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk_o    (sclk_o),
        .sdata_i   (sdata_i),
        .irq_o     (irq_o)
    );

    // serial slave model: new bit after each rising edge of the internal clock
    initial begin
        forever begin
            @(negedge clk);
            if ((sclk_o ^ inv_tb) && !prev_eff) begin
                sdata_i = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
            end
            prev_eff = sclk_o ^ inv_tb;
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: queue serial bits and, optionally, the expected word
    task automatic push_word(input logic [8:0] w, input int nbits, input bit expect_it);
        for (int i = 0; i < nbits; i++) bitq.push_back(w[i]);
        if (expect_it) expq.push_back(w);
    endtask

    // monitor: wait for each word, pop and compare
    task automatic collect(input int n, input string req);
        logic [7:0] s, d;
        logic [8:0] e;
        for (int k = 0; k < n; k++) begin
            while (!irq_o) @(negedge clk);
            e = expq.pop_front();
            rd(STAT, s);
            chk(req, "status", {8'h0, s}, {8'h0, 5'b0, e[8], 1'b0, 1'b1});
            rd(DATA, d);
            chk(req, "data (R4 lsb first)", {8'h0, d}, {8'h0, e[7:0]});
            chk("R8", "irq after data read", {15'h0, irq_o}, 16'h0);
        end
    endtask

    task automatic measure_high(output int c);
        c = 0;
        while (!(sclk_o ^ inv_tb)) @(negedge clk);
        while (sclk_o ^ inv_tb) begin
            @(negedge clk);
            c++;
        end
    endtask

    initial begin
        logic [7:0] r;
        int         hw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "sclk", {15'h0, sclk_o}, 16'h0);
        chk("R1", "irq", {15'h0, irq_o}, 16'h0);
        rd(STAT, r); chk("R1", "status", {8'h0, r}, 16'h0);
        rd(CTRL, r); chk("R1", "control", {8'h0, r}, 16'h0);

        // R2/R6 one-shot word, narrow divisor 2
        wr(DLO, 8'd2); wr(DHI, 8'd0);
        push_word(9'h0A5, 8, 1'b1);
        wr(CTRL, PORT | ONE | IEN);
        measure_high(hw);
        chk("R6", "half period div=2", 16'(hw), 16'd3);
        collect(1, "R2");
        rd(CTRL, r); chk("R2", "one-shot self-clear", {15'h0, r[1]}, 16'h0);
        repeat (60) @(negedge clk);
        chk("R2", "clock idle after word", {15'h0, sclk_o}, 16'h0);
        rd(STAT, r); chk("R2", "no second word", {8'h0, r}, 16'h0);

        // R3 repeating reception
        push_word(9'h03C, 8, 1'b1);
        push_word(9'h0C3, 8, 1'b1);
        push_word(9'h001, 8, 1'b1);
        wr(CTRL, PORT | REP | IEN);
        collect(3, "R3");
        wr(CTRL, PORT | IEN);
        repeat (5) @(negedge clk);
        chk("R3", "clock idle after stop", {15'h0, sclk_o}, 16'h0);

        // R3 both enables: repeating wins
        push_word(9'h080, 8, 1'b1);
        push_word(9'h05A, 8, 1'b1);
        wr(CTRL, PORT | ONE | REP | IEN);
        collect(2, "R3");
        wr(CTRL, PORT | IEN);
        repeat (5) @(negedge clk);

        // R7 nine-bit words
        push_word(9'h1F0, 9, 1'b1);
        push_word(9'h00F, 9, 1'b1);
        wr(CTRL, PORT | REP | NINE | IEN);
        collect(2, "R7");
        wr(CTRL, PORT | IEN);
        repeat (5) @(negedge clk);

        // R5 inverted clock
        wr(CTRL, PORT | INV | IEN);
        chk("R5", "inverted idle level", {15'h0, sclk_o}, 16'h1);
        inv_tb = 1'b1;
        @(negedge clk);
        push_word(9'h096, 8, 1'b1);
        wr(CTRL, PORT | INV | ONE | IEN);
        measure_high(hw);
        chk("R5", "inverted half period", 16'(hw), 16'd3);
        collect(1, "R5");
        chk("R5", "idle after inverted word", {15'h0, sclk_o}, 16'h1);
        wr(CTRL, PORT | IEN);
        inv_tb = 1'b0;
        @(negedge clk);
        chk("R5", "normal idle level", {15'h0, sclk_o}, 16'h0);

        // R6 narrow divisor ignores high byte
        wr(DLO, 8'd1); wr(DHI, 8'd1);
        push_word(9'h0E7, 8, 1'b1);
        wr(CTRL, PORT | ONE | IEN);
        measure_high(hw);
        chk("R6", "narrow ignores high byte", 16'(hw), 16'd2);
        collect(1, "R6");

        // R6 wide divisor {1,0} = 256
        wr(DLO, 8'd0);
        push_word(9'h03B, 8, 1'b1);
        wr(CTRL, PORT | WIDE | ONE | IEN);
        measure_high(hw);
        chk("R6", "wide half period", 16'(hw), 16'd257);
        collect(1, "R6");

        // R9 overrun, interrupt masked (R8)
        wr(DLO, 8'd2); wr(DHI, 8'd0);
        wr(CTRL, PORT);
        push_word(9'h04D, 8, 1'b0);
        push_word(9'h077, 8, 1'b0);
        push_word(9'h099, 8, 1'b0);
        wr(CTRL, PORT | REP);
        repeat (180) @(negedge clk);
        chk("R8", "irq masked while done", {15'h0, irq_o}, 16'h0);
        rd(STAT, r); chk("R9", "done and overrun", {8'h0, r}, 16'h3);
        wr(CTRL, PORT);
        rd(STAT, r); chk("R9", "overrun cleared", {8'h0, r}, 16'h1);
        rd(DATA, r); chk("R9", "first word kept", {8'h0, r}, 16'h4D);
        rd(STAT, r); chk("R8", "done cleared by read", {8'h0, r}, 16'h0);

        // R10 port off blocks reception
        bitq.delete();
        wr(CTRL, ONE | IEN);
        repeat (100) begin
            @(negedge clk);
            if (sclk_o !== 1'b0) break;
        end
        chk("R10", "clock held idle", {15'h0, sclk_o}, 16'h0);
        rd(STAT, r); chk("R10", "no word received", {8'h0, r}, 16'h0);
        wr(CTRL, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule